// File: doc/BRIEF.md
# Reconfigurable Pin Function Crossbar

This block sits between 24 general-purpose pads, grouped as three ports of eight, and the on-chip peripherals that want to reach them. Every pad owns a 5-bit mapping code that selects one peripheral function. For most codes the pad's direction bit picks the meaning. With the bit clear the pad feeds a peripheral input, such as a timer capture or timer clock. With the bit set the pad is driven by a peripheral output, such as a compare output or a clock output. Serial and radio codes are different: the peripheral drives its own output enable, and the direction bit is ignored.

The mapping codes are written and read through a small synchronous register bus, one address per pad. Toward the pads the block produces an output value, output enable, open-drain flag and input-buffer enable for each pad. Toward the peripherals it produces the merged input signals. It also resolves the two codes that are shared between a serial clock and the other serial unit's slave enable. When the clock claims such a pin, the crossbar tells the other unit to fall back to 3-wire operation.

Top module: `pin_xbar`

## Requirements
- R1: A write with `busWe` high and `busAddr` below 24 stores `busWdata[4:0]` into that pad's code register at the clock edge, so 0xFF reads back as 31. Writes to addresses 24..31 change nothing, and those addresses read 0. `busRdata` shows the register at `busAddr` combinationally.
- R2: Code 31 (analog) forces `padOe`, `padIe`, `padOut` and `padOd` low for that pad, and the pad feeds no peripheral input.
- R3: Code 0 and codes 26..30 feed no peripheral input and keep `padIe` high. With the direction bit set they drive `padOe`=1 and `padOut`=0.
- R4: For ordinary codes with the direction bit set, `padOe`=1 and `padOut` carries the source. Codes 1 and 2 carry `cmpOut`, code 3+k carries `sysOut[k]` (k=0..5), and code 9+k carries `tmrCmpOut[k]` (k=0..7). With the direction bit clear, `padOe`=0 and `padOut`=0, and the pad feeds the input for its code. Code 1 feeds `tmrClkIn[0]`, code 2 feeds `tmrClkIn[1]`, code 7 feeds `dmaTrigIn`, and code 9+k feeds `tmrCapIn[k]`. Codes 3..6 and 8 have no input.
- R5: Codes 17..22 (serial slot k=code-17) and 23..25 (radio slot r=code-23) ignore `pinDir`. `padOe`/`padOut` follow `serOe[k]`/`serOut[k]` or `rfOe[r]`/`rfOut[r]`, and the pad always feeds `serIn[k]` or `rfIn[r]`.
- R6: When `bI2cMode` is high, codes 20 and 21 set `padOd`=1 and `padOut`=0, with `padOe`=`serOe[k]` AND NOT `serOut[k]`. The pad can only pull low.
- R7: When `aClkActive` is high, code 19 acts as serial slot 2 (unit A clock). `bForce3Wire` is then high whenever at least one pad holds code 19. When `aClkActive` is low, code-19 pads are inputs only (`padOe`=0, `padOut`=0) and feed `steBIn` instead of `serIn[2]`. Code 22 behaves the same way with `bClkActive`, `serIn[5]`, `steAIn` and `aForce3Wire`.
- R8: A peripheral input is the OR of all pads currently feeding it, and it is 0 when no pad feeds it.
- R9: After reset the 24 codes are: port 0 pads 0..7 = 23,25,20,21,22,17,18,19; port 1 = 2,14,15,16,6,8,3,7; port 2 = 1,9,10,11,12,13,24,5 (pad index = 8*port + bit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Code register write strobe |
| busAddr | input | 5 | Pad index for read and write |
| busWdata | input | 8 | Write data (upper bits dropped) |
| busRdata | output | 5 | Code of the addressed pad |
| pinDir | input | 24 | Per-pad direction bit (1 = output) |
| padIn | input | 24 | Pad input values |
| padOut | output | 24 | Pad output values |
| padOe | output | 24 | Pad output enables |
| padOd | output | 24 | Pad open-drain flags |
| padIe | output | 24 | Pad input-buffer enables |
| cmpOut | input | 1 | Comparator output source |
| sysOut | input | 6 | Clock and supervisor output sources (codes 3..8) |
| tmrCmpOut | input | 8 | Timer compare outputs (codes 9..16) |
| tmrCapIn | output | 8 | Timer capture inputs |
| tmrClkIn | output | 2 | Timer external clock inputs |
| dmaTrigIn | output | 1 | DMA external trigger input |
| serOut | input | 6 | Serial pin output values (codes 17..22) |
| serOe | input | 6 | Serial pin output enables |
| serIn | output | 6 | Serial pin input values |
| aClkActive | input | 1 | Unit A needs its clock pin |
| bClkActive | input | 1 | Unit B needs its clock pin |
| bI2cMode | input | 1 | Unit B runs I2C |
| steAIn | output | 1 | Unit A slave-enable input |
| steBIn | output | 1 | Unit B slave-enable input |
| aForce3Wire | output | 1 | Forces unit A to 3-wire mode |
| bForce3Wire | output | 1 | Forces unit B to 3-wire mode |
| rfOut | input | 3 | Radio pin output values (codes 23..25) |
| rfOe | input | 3 | Radio pin output enables |
| rfIn | output | 3 | Radio pin input values |

## Verification
The hardest situations to reach are the ones that involve several pads at once. A code-19 or code-22 pad must be checked both with and without the clock claim. Several pads that share one input code must be seen with sparse input levels, so that the OR and the all-zero cases both appear. The bench therefore writes random codes, including out-of-range byte values and out-of-range addresses, into all 24 registers over thousands of cycles. It toggles the serial mode inputs every few dozen cycles and alternates between dense and sparse pad input phases. Every cycle it compares all outputs against a behavioural model. Directed steps add an all-analog map and a map where every pad holds the same capture code.

// File: rtl/pin_xbar_pkg.sv
package pin_xbar_pkg;
  localparam int CODE_W    = 5;
  localparam int ADDR_W    = 5;
  localparam int NUM_CODES = 1 << CODE_W;

  localparam logic [CODE_W-1:0] CODE_ANALOG = 5'd31;
  localparam logic [CODE_W-1:0] CODE_ACLK   = 5'd19;
  localparam logic [CODE_W-1:0] CODE_BCLK   = 5'd22;

  // codes whose pin direction belongs to a peripheral (17..25)
  localparam logic [NUM_CODES-1:0] OWNED_MASK = 32'h03FE_0000;
  // ordinary codes that have an input meaning: 1, 2, 7, 9..16
  localparam logic [NUM_CODES-1:0] INPUT_MASK = 32'h0001_FE86;
  // serial codes that turn open-drain in I2C mode: 20, 21
  localparam logic [NUM_CODES-1:0] I2C_MASK   = 32'h0030_0000;

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] pin;
    logic [CODE_W-1:0] code;
  } wrStrobe_t;

  function automatic logic [CODE_W-1:0] resetCode(input int pin);
    case (pin)
      0: return 5'd23;  1: return 5'd25;  2: return 5'd20;  3: return 5'd21;
      4: return 5'd22;  5: return 5'd17;  6: return 5'd18;  7: return 5'd19;
      8: return 5'd2;   9: return 5'd14; 10: return 5'd15; 11: return 5'd16;
     12: return 5'd6;  13: return 5'd8;  14: return 5'd3;  15: return 5'd7;
     16: return 5'd1;  17: return 5'd9;  18: return 5'd10; 19: return 5'd11;
     20: return 5'd12; 21: return 5'd13; 22: return 5'd24; 23: return 5'd5;
      default: return 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/pin_xbar_ctrl.sv
module pin_xbar_ctrl
  import pin_xbar_pkg::*;
#(
  parameter int NPINS = 24
) (
  input  logic                    busWe,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic [7:0]              busWdata,
  input  logic [NPINS*CODE_W-1:0] mapFlat,
  output wrStrobe_t               stb,
  output logic [CODE_W-1:0]       busRdata
);
  logic addrOk;
  assign addrOk = busAddr < ADDR_W'(NPINS);

  always_comb begin
    stb.wrEn = busWe && addrOk;
    stb.pin  = busAddr;
    stb.code = busWdata[CODE_W-1:0];
  end

  always_comb begin
    busRdata = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (busAddr == ADDR_W'(i)) busRdata = mapFlat[i*CODE_W +: CODE_W];
    end
  end
endmodule

// File: rtl/pin_xbar_dp.sv
module pin_xbar_dp
  import pin_xbar_pkg::*;
#(
  parameter int NPINS = 24
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  wrStrobe_t               stb,
  input  logic [NPINS-1:0]        pinDir,
  input  logic [NPINS-1:0]        padIn,
  output logic [NPINS-1:0]        padOut,
  output logic [NPINS-1:0]        padOe,
  output logic [NPINS-1:0]        padOd,
  output logic [NPINS-1:0]        padIe,
  output logic [NPINS*CODE_W-1:0] mapFlat,
  input  logic                    cmpOut,
  input  logic [5:0]              sysOut,
  input  logic [7:0]              tmrCmpOut,
  input  logic [5:0]              serOut,
  input  logic [5:0]              serOe,
  input  logic [2:0]              rfOut,
  input  logic [2:0]              rfOe,
  input  logic                    aClkActive,
  input  logic                    bClkActive,
  input  logic                    bI2cMode,
  output logic [NUM_CODES-1:0]    feedAll,
  output logic [NUM_CODES-1:0]    hitAll
);
  logic [NUM_CODES-1:0] srcOut, srcOe;
  logic [NUM_CODES-1:0] pinFeed [NPINS];
  logic [NUM_CODES-1:0] pinHit  [NPINS];

  // peripheral sources laid out by mapping code
  always_comb begin
    srcOut        = '0;
    srcOe         = '0;
    srcOut[1]     = cmpOut;
    srcOut[2]     = cmpOut;
    srcOut[8:3]   = sysOut;
    srcOut[16:9]  = tmrCmpOut;
    srcOut[22:17] = serOut;
    srcOe[22:17]  = serOe;
    srcOut[25:23] = rfOut;
    srcOe[25:23]  = rfOe;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    localparam logic [ADDR_W-1:0] PIN_ID = ADDR_W'(i);
    logic [CODE_W-1:0] code;
    logic pOut, pOe, pOd, pIe, slaveOnly;
    logic [NUM_CODES-1:0] pFeed;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) code <= resetCode(i);
      else if (stb.wrEn && stb.pin == PIN_ID) code <= stb.code;
    end

    assign slaveOnly = (code == CODE_ACLK && !aClkActive) ||
                       (code == CODE_BCLK && !bClkActive);

    always_comb begin
      pOut  = 1'b0;
      pOe   = 1'b0;
      pOd   = 1'b0;
      pIe   = (code != CODE_ANALOG);
      pFeed = '0;
      if (code == CODE_ANALOG) begin
        pIe = 1'b0;
      end else if (OWNED_MASK[code]) begin
        pFeed[code] = padIn[i];
        if (slaveOnly) begin
          pOe = 1'b0;
        end else if (I2C_MASK[code] && bI2cMode) begin
          pOd = 1'b1;
          pOe = srcOe[code] & ~srcOut[code];
        end else begin
          pOe  = srcOe[code];
          pOut = srcOut[code];
        end
      end else if (pinDir[i]) begin
        pOe  = 1'b1;
        pOut = srcOut[code];
      end else begin
        pFeed[code] = padIn[i] & INPUT_MASK[code];
      end
    end

    assign padOut[i]  = pOut;
    assign padOe[i]   = pOe;
    assign padOd[i]   = pOd;
    assign padIe[i]   = pIe;
    assign pinFeed[i] = pFeed;
    assign pinHit[i]  = NUM_CODES'(1) << code;
    assign mapFlat[i*CODE_W +: CODE_W] = code;
  end

  always_comb begin
    feedAll = '0;
    hitAll  = '0;
    for (int i = 0; i < NPINS; i++) begin
      feedAll |= pinFeed[i];
      hitAll  |= pinHit[i];
    end
  end
endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
  import pin_xbar_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int PORT_PINS = 8
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 busWe,
  input  logic [4:0]                           busAddr,
  input  logic [7:0]                           busWdata,
  output logic [4:0]                           busRdata,
  input  logic [NUM_PORTS*PORT_PINS-1:0]       pinDir,
  input  logic [NUM_PORTS*PORT_PINS-1:0]       padIn,
  output logic [NUM_PORTS*PORT_PINS-1:0]       padOut,
  output logic [NUM_PORTS*PORT_PINS-1:0]       padOe,
  output logic [NUM_PORTS*PORT_PINS-1:0]       padOd,
  output logic [NUM_PORTS*PORT_PINS-1:0]       padIe,
  input  logic                                 cmpOut,
  input  logic [5:0]                           sysOut,
  input  logic [7:0]                           tmrCmpOut,
  output logic [7:0]                           tmrCapIn,
  output logic [1:0]                           tmrClkIn,
  output logic                                 dmaTrigIn,
  input  logic [5:0]                           serOut,
  input  logic [5:0]                           serOe,
  output logic [5:0]                           serIn,
  input  logic                                 aClkActive,
  input  logic                                 bClkActive,
  input  logic                                 bI2cMode,
  output logic                                 steAIn,
  output logic                                 steBIn,
  output logic                                 aForce3Wire,
  output logic                                 bForce3Wire,
  input  logic [2:0]                           rfOut,
  input  logic [2:0]                           rfOe,
  output logic [2:0]                           rfIn
);
  localparam int NPINS = NUM_PORTS * PORT_PINS;

  wrStrobe_t               stb;
  logic [NPINS*CODE_W-1:0] mapFlat;
  logic [NUM_CODES-1:0]    feedAll, hitAll;

  pin_xbar_ctrl #(.NPINS(NPINS)) u_ctrl (
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .mapFlat(mapFlat), .stb(stb), .busRdata(busRdata)
  );

  pin_xbar_dp #(.NPINS(NPINS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .pinDir(pinDir), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .padOd(padOd), .padIe(padIe),
    .mapFlat(mapFlat), .cmpOut(cmpOut), .sysOut(sysOut), .tmrCmpOut(tmrCmpOut),
    .serOut(serOut), .serOe(serOe), .rfOut(rfOut), .rfOe(rfOe),
    .aClkActive(aClkActive), .bClkActive(bClkActive), .bI2cMode(bI2cMode),
    .feedAll(feedAll), .hitAll(hitAll)
  );

  assign tmrClkIn    = feedAll[2:1];
  assign dmaTrigIn   = feedAll[7];
  assign tmrCapIn    = feedAll[16:9];
  assign serIn       = {feedAll[22] & bClkActive, feedAll[21:20],
                        feedAll[19] & aClkActive, feedAll[18:17]};
  assign steBIn      = feedAll[19] & ~aClkActive;
  assign steAIn      = feedAll[22] & ~bClkActive;
  assign rfIn        = feedAll[25:23];
  assign bForce3Wire = aClkActive & hitAll[19];
  assign aForce3Wire = bClkActive & hitAll[22];
endmodule

// File: rtl/pin_xbar_chk.sv
module pin_xbar_chk #(
  parameter int NPINS = 24
) (
  input logic               clk,
  input logic               rstN,
  input logic               busWe,
  input logic [4:0]         busAddr,
  input logic [7:0]         busWdata,
  input logic [4:0]         busRdata,
  input logic [NPINS-1:0]   padOut,
  input logic [NPINS-1:0]   padOe,
  input logic [NPINS-1:0]   padOd,
  input logic [NPINS-1:0]   padIe,
  input logic [NPINS*5-1:0] mapFlat,
  input logic               aClkActive,
  input logic               bClkActive,
  input logic               aForce3Wire,
  input logic               bForce3Wire
);
  p_wr_readback_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr < 5'(NPINS)) |=>
      (busAddr != $past(busAddr)) || (busRdata == $past(busWdata[4:0])));

  p_force_b_r7: assert property (@(posedge clk) disable iff (!rstN)
    bForce3Wire |-> aClkActive);

  p_force_a_r7: assert property (@(posedge clk) disable iff (!rstN)
    aForce3Wire |-> bClkActive);

  for (genvar i = 0; i < NPINS; i++) begin : g_chk
    p_analog_off_r2: assert property (@(posedge clk) disable iff (!rstN)
      (mapFlat[i*5 +: 5] == 5'd31) |-> (!padOe[i] && !padIe[i] && !padOut[i]));

    p_digital_ie_r3: assert property (@(posedge clk) disable iff (!rstN)
      (mapFlat[i*5 +: 5] != 5'd31) |-> padIe[i]);

    p_od_low_r6: assert property (@(posedge clk) disable iff (!rstN)
      padOd[i] |-> !padOut[i]);
  end
endmodule

bind pin_xbar pin_xbar_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
  .busRdata(busRdata), .padOut(padOut), .padOe(padOe), .padOd(padOd), .padIe(padIe),
  .mapFlat(mapFlat), .aClkActive(aClkActive), .bClkActive(bClkActive),
  .aForce3Wire(aForce3Wire), .bForce3Wire(bForce3Wire)
);

// File: tb/sim_pin_xbar.sv
module sim_pin_xbar;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0;
  logic [4:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [4:0] busRdata;
  logic [23:0] pinDir = '0, padIn = '0;
  logic [23:0] padOut, padOe, padOd, padIe;
  logic cmpOut = 1'b0;
  logic [5:0] sysOut = '0, serOut = '0, serOe = '0, serIn;
  logic [7:0] tmrCmpOut = '0, tmrCapIn;
  logic [1:0] tmrClkIn;
  logic dmaTrigIn, steAIn, steBIn, aForce3Wire, bForce3Wire;
  logic aClkActive = 1'b0, bClkActive = 1'b0, bI2cMode = 1'b0;
  logic [2:0] rfOut = '0, rfOe = '0, rfIn;

  int nChk = 0, nFail = 0;
  int mMap [24];
  bit done = 0;

  always #5 clk = ~clk;

  pin_xbar u0 (.*);

  task automatic chk(string tag, string nm, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, nm, act, exp);
    end
  endtask

  // behavioural reference of all outputs from the model map
  task automatic compare(string rdTag);
    logic [23:0] eOut = '0, eOe = '0, eOd = '0, eIe = '0;
    logic [31:0] feed = '0, hit = '0;
    for (int p = 0; p < 24; p++) begin
      int c = mMap[p];
      hit[c] = 1'b1;
      if (c == 31) begin
        // R2: analog, everything off
      end else begin
        eIe[p] = 1'b1;  // R3 / R4: digital codes keep the input buffer
        if (c >= 17 && c <= 25) begin  // R5: peripheral-owned direction
          feed[c] = feed[c] | padIn[p];
          if (c >= 23) begin
            eOe[p] = rfOe[c-23]; eOut[p] = rfOut[c-23];
          end else if ((c == 19 && !aClkActive) || (c == 22 && !bClkActive)) begin
            // R7: slave-enable input only
          end else if ((c == 20 || c == 21) && bI2cMode) begin
            eOd[p] = 1'b1; eOe[p] = serOe[c-17] & ~serOut[c-17];  // R6
          end else begin
            eOe[p] = serOe[c-17]; eOut[p] = serOut[c-17];
          end
        end else if (pinDir[p]) begin
          eOe[p] = 1'b1;
          if (c == 1 || c == 2) eOut[p] = cmpOut;
          else if (c >= 3 && c <= 8) eOut[p] = sysOut[c-3];
          else if (c >= 9 && c <= 16) eOut[p] = tmrCmpOut[c-9];
          else eOut[p] = 1'b0;
        end else if (c == 1 || c == 2 || c == 7 || (c >= 9 && c <= 16)) begin
          feed[c] = feed[c] | padIn[p];
        end
      end
    end
    chk(rdTag, "busRdata", 32'(busRdata), (busAddr < 24) ? 32'(mMap[busAddr]) : 32'd0);
    chk("R4", "padOut", 32'(padOut), 32'(eOut));
    chk("R4", "padOe", 32'(padOe), 32'(eOe));
    chk("R6", "padOd", 32'(padOd), 32'(eOd));
    chk("R2", "padIe", 32'(padIe), 32'(eIe));
    chk("R8", "tmrCapIn", 32'(tmrCapIn), 32'(feed[16:9]));
    chk("R8", "tmrClkIn", 32'(tmrClkIn), 32'(feed[2:1]));
    chk("R8", "dmaTrigIn", 32'(dmaTrigIn), 32'(feed[7]));
    chk("R5", "serIn", 32'(serIn),
        32'({feed[22] & bClkActive, feed[21:20], feed[19] & aClkActive, feed[18:17]}));
    chk("R7", "steBIn", 32'(steBIn), 32'(feed[19] & ~aClkActive));
    chk("R7", "steAIn", 32'(steAIn), 32'(feed[22] & ~bClkActive));
    chk("R5", "rfIn", 32'(rfIn), 32'(feed[25:23]));
    chk("R7", "bForce3Wire", 32'(bForce3Wire), 32'(aClkActive & hit[19]));
    chk("R7", "aForce3Wire", 32'(aForce3Wire), 32'(bClkActive & hit[22]));
  endtask

  task automatic tick(string rdTag);
    @(negedge clk);
    compare(rdTag);
    @(posedge clk);
    if (rstN && busWe && busAddr < 24) mMap[busAddr] = int'(busWdata[4:0]);  // R1
    #1;
  endtask

  task automatic randPeriph();
    cmpOut = 1'($urandom); sysOut = 6'($urandom); tmrCmpOut = 8'($urandom);
    serOut = 6'($urandom); serOe = 6'($urandom);
    rfOut = 3'($urandom); rfOe = 3'($urandom);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    // R9: reset table as written in the requirement
    automatic int dflt[24] = '{23,25,20,21,22,17,18,19, 2,14,15,16,6,8,3,7,
                               1,9,10,11,12,13,24,5};
    for (int i = 0; i < 24; i++) mMap[i] = dflt[i];
    @(posedge clk); #1;
    tick("R9");
    rstN = 1'b1;
    // R9: read every address with no writes
    for (int a = 0; a < 32; a++) begin
      busAddr = 5'(a); pinDir = 24'($urandom); padIn = 24'($urandom); randPeriph();
      tick("R9");
    end
    // R1: writes to addresses past the last pad, then readback sweep
    for (int a = 24; a < 32; a++) begin
      busWe = 1'b1; busAddr = 5'(a); busWdata = 8'($urandom); tick("R1");
    end
    busWe = 1'b0;
    for (int a = 0; a < 32; a++) begin busAddr = 5'(a); tick("R1"); end
    // R2: every pad analog via 0xFF
    for (int a = 0; a < 24; a++) begin
      busWe = 1'b1; busAddr = 5'(a); busWdata = 8'hFF; padIn = '1; tick("R1");
    end
    busWe = 1'b0; pinDir = '1; tick("R2"); pinDir = '0; tick("R2");
    // R8: every pad on capture code 9, none high then one high
    for (int a = 0; a < 24; a++) begin
      busWe = 1'b1; busAddr = 5'(a); busWdata = 8'd9; padIn = '0; tick("R1");
    end
    busWe = 1'b0; pinDir = '0; padIn = '0; tick("R8");
    padIn = 24'h000400; tick("R8");
    // R3 / R5 / R6 / R7: random maps, modes and pad levels
    for (int n = 0; n < 4000; n++) begin
      busWe = ($urandom % 2) == 0;
      busAddr = 5'($urandom);
      busWdata = ($urandom % 4 == 0) ? 8'(26 + $urandom % 6) : 8'($urandom);
      pinDir = 24'($urandom);
      if ((n / 400) % 2 == 0) padIn = 24'($urandom);
      else padIn = 24'($urandom & $urandom & $urandom & $urandom);
      if (n % 48 == 0) begin
        aClkActive = 1'($urandom); bClkActive = 1'($urandom); bI2cMode = 1'($urandom);
      end
      randPeriph();
      tick("R1");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule